// File: doc/BRIEF.md
# CAN Controller Power-Mode Manager

This block holds the mode-control state of a CAN controller. It does not contain the protocol engine, bit timing, message storage or the clock gating cell. It decides when the protocol core's clock may run, and it reports through two read-only flags whether a freeze or a stop has actually taken hold. Software uses a small register port to reach a control register at address 0 and a bank of protected registers. The protected bank stands in for the controller's privileged registers. A supervisor-only bit gates access to that bank.

The core clock enable drops on an explicit stop request, or in auto power save mode whenever the core reports no pending work. The gating cell answers with a clock-running level. A freeze request halts the bit-rate prescaler, and the prescaler answers with a running level. When self-wake is enabled during stop, the block watches the synchronized receive line. A fall from recessive (1) to dominant (0) clears the stop request with no software action. A control write that would set self-wake in the same cycle as such a fall is refused, both for self-wake and for the stop bit.

Top module: `can_pwr_mode_mgr`

## Requirements
- R1: After reset the control register reads 0x10: only the supervisor-only bit is set. The clock enable is 1, the prescaler halt is 0 and `acc_err` is 0.
- R2: Control register layout: bit0 stop request, bit1 freeze request, bit2 self-wake, bit3 auto power save, bit4 supervisor-only, bit5 freeze acknowledge (read-only), bit6 stop acknowledge (read-only). While the stop bit is 1, `core_clk_en` is 0 from the cycle after the bit is set.
- R3: The stop acknowledge bit sets only while stop is requested, the enable is low and `clk_running` is 0. It clears only when `clk_running` is 1. Gating by auto power save never sets it.
- R4: `presc_halt` follows the freeze bit. The freeze acknowledge sets once `presc_run` is 0 with freeze requested. It clears only after the freeze bit is cleared and `presc_run` is 1.
- R5: `can_rx` passes through two synchronizing flops. A synchronized 1-to-0 step, seen while stop and self-wake are both set, clears the stop bit on the next edge and so re-enables the clock. A 0-to-1 step has no effect.
- R6: A control write carrying self-wake 1 while self-wake is 0, in the cycle a synchronized fall is detected, leaves self-wake at 0 and the stop bit unchanged. The other bits of that write take effect.
- R7: With auto power save set and stop clear, `core_clk_en` equals `core_busy` delayed by one cycle.
- R8: Addresses 1 to 4 are protected. With the supervisor-only bit at 1, an access with `acc_supv` 0 reads as 0, does not write, and raises `acc_err` for one cycle. With the bit at 0, user accesses behave as supervisor ones.
- R9: `acc_err` is 1 only in the cycle after a refused access.
- R10: Read data is registered and is valid in the cycle after the read access. The control register at address 0 is open to any privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (always running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_supv | input | 1 | Access carries supervisor privilege |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, one cycle after the access |
| acc_err | output | 1 | Refused protected access, one-cycle pulse |
| can_rx | input | 1 | CAN receive line, 1 recessive, 0 dominant |
| core_busy | input | 1 | Protocol core has pending work |
| clk_running | input | 1 | Gating cell reports the core clock running |
| presc_run | input | 1 | Bit-rate prescaler reports running |
| core_clk_en | output | 1 | Clock enable to the gating cell |
| presc_halt | output | 1 | Halt request to the prescaler |

## Verification
Read data and `acc_err` are due one edge after the access cycle. `core_clk_en` is due two edges after a control write: one edge to register the bit and one to register the enable. The acknowledge flags move on the edge after the handshake level they wait for. A fall on `can_rx` is detected after the second synchronizer edge, clears stop on the third and raises the enable on the fourth. The bench keeps a behavioural model that steps on every rising edge. It compares all outputs at the falling edge, half a period after each registered result is due, and it times the self-wake race write to land exactly on the detection cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

  localparam int B_STOP  = 0;
  localparam int B_FRZ   = 1;
  localparam int B_SWAKE = 2;
  localparam int B_APS   = 3;
  localparam int B_SUPV  = 4;
  localparam int B_FACK  = 5;
  localparam int B_SACK  = 6;
  localparam int CTL_BITS = 7;

  typedef struct packed {
    logic supv;
    logic aps;
    logic swake;
    logic frz;
    logic stop;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{supv: 1'b1, aps: 1'b0, swake: 1'b0, frz: 1'b0, stop: 1'b0};

  // Clock may run unless stopped or parked by auto power save with no work.
  function automatic logic clk_wanted(input logic stop, input logic aps, input logic busy);
    return !stop && !(aps && !busy);
  endfunction

  // Recessive-to-dominant step between two successive synchronized samples.
  function automatic logic is_fall(input logic older, input logic newer);
    return older && !newer;
  endfunction

  function automatic logic [CTL_BITS-1:0] pack_ctl(input ctl_t c, input logic fack, input logic sack);
    logic [CTL_BITS-1:0] v;
    v = '0;
    v[B_STOP]  = c.stop;
    v[B_FRZ]   = c.frz;
    v[B_SWAKE] = c.swake;
    v[B_APS]   = c.aps;
    v[B_SUPV]  = c.supv;
    v[B_FACK]  = fack;
    v[B_SACK]  = sack;
    return v;
  endfunction

endpackage

// File: rtl/pmm_rx_edge.sv
module pmm_rx_edge
  import pmm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic fall_evt
);

  logic [STAGES-1:0] chain;
  logic              prev_q;
  logic              rx_sync;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_sync
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= 1'b1;
        else        chain[gi] <= rx_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= 1'b1;
        else        chain[gi] <= chain[gi-1];
      end
    end
  end

  assign rx_sync = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_sync;
  end

  assign fall_evt = is_fall(prev_q, rx_sync);

  // R5: a detected fall lasts a single cycle
  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/pmm_clk_ctl.sv
module pmm_clk_ctl
  import pmm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic frz_req,
  input  logic aps_en,
  input  logic core_busy,
  input  logic clk_running,
  input  logic presc_run,
  output logic clk_en_q,
  output logic stop_ack_q,
  output logic frz_ack_q
);

  logic want_clk;
  logic sack_set, sack_clr;
  logic fack_set, fack_clr;

  assign want_clk = clk_wanted(stop_req, aps_en, core_busy);
  assign sack_set = stop_req && !clk_en_q && !clk_running;
  assign sack_clr = clk_running;
  assign fack_set = frz_req && !presc_run;
  assign fack_clr = !frz_req && presc_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q   <= 1'b1;
      stop_ack_q <= 1'b0;
      frz_ack_q  <= 1'b0;
    end else begin
      clk_en_q <= want_clk;
      if (sack_set)      stop_ack_q <= 1'b1;
      else if (sack_clr) stop_ack_q <= 1'b0;
      if (fack_set)      frz_ack_q <= 1'b1;
      else if (fack_clr) frz_ack_q <= 1'b0;
    end
  end

  p_stop_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !clk_en_q);

  p_sack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack_q) |-> $past(stop_req && !clk_running));

  p_sack_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_ack_q) |-> $past(clk_running));

  p_fack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack_q) |-> $past(frz_req && !presc_run));

  p_fack_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_ack_q) |-> $past(presc_run && !frz_req));

  p_aps_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aps_en && !core_busy) |=> !clk_en_q);

endmodule

// File: rtl/pmm_regs.sv
module pmm_regs
  import pmm_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int NUM_PROT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_supv,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              fall_evt,
  input  logic              frz_ack,
  input  logic              stop_ack,
  output ctl_t              ctl_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic              wake_evt,
  output logic              race_evt,
  output logic              deny_evt
);

  localparam int PIDX_W = (NUM_PROT > 1) ? $clog2(NUM_PROT) : 1;

  logic                             ctl_hit, prot_hit, wr_ctl, wr_prot;
  logic [PIDX_W-1:0]                pidx;
  ctl_t                             ctl_n;
  logic [DATA_W-1:0]                rd_n;
  logic [NUM_PROT-1:0][DATA_W-1:0]  prot_flat;

  assign ctl_hit  = acc_valid && (acc_addr == '0);
  assign prot_hit = acc_valid && (int'(acc_addr) >= 1) && (int'(acc_addr) <= NUM_PROT);
  assign pidx     = PIDX_W'(int'(acc_addr) - 1);
  assign deny_evt = prot_hit && ctl_q.supv && !acc_supv;
  assign wr_ctl   = ctl_hit && acc_write;
  assign wr_prot  = prot_hit && acc_write && !deny_evt;
  assign race_evt = wr_ctl && acc_wdata[B_SWAKE] && !ctl_q.swake && fall_evt;
  assign wake_evt = ctl_q.stop && ctl_q.swake && fall_evt;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctl) begin
      ctl_n.frz  = acc_wdata[B_FRZ];
      ctl_n.aps  = acc_wdata[B_APS];
      ctl_n.supv = acc_wdata[B_SUPV];
      if (!race_evt) begin
        ctl_n.stop  = acc_wdata[B_STOP];
        ctl_n.swake = acc_wdata[B_SWAKE];
      end
    end
    if (wake_evt) ctl_n.stop = 1'b0;
  end

  always_comb begin
    rd_n = '0;
    if (acc_valid && !acc_write) begin
      if (ctl_hit)                    rd_n = DATA_W'(pack_ctl(ctl_q, frz_ack, stop_ack));
      else if (prot_hit && !deny_evt) rd_n = prot_flat[pidx];
    end
  end

  for (genvar gi = 0; gi < NUM_PROT; gi++) begin : g_prot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_prot && (pidx == PIDX_W'(gi)))   q <= acc_wdata;
    end
    assign prot_flat[gi] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      rd_data <= '0;
      acc_err <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      rd_data <= rd_n;
      acc_err <= deny_evt;
    end
  end

  p_deny_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_evt && !acc_write) |=> (acc_err && rd_data == '0));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(deny_evt));

  p_race_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    race_evt |=> (!ctl_q.swake && (ctl_q.stop == $past(ctl_q.stop))));

  p_wake_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !ctl_q.stop);

endmodule

// File: rtl/can_pwr_mode_mgr.sv
module can_pwr_mode_mgr
  import pmm_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int NUM_PROT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_supv,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  input  logic              can_rx,
  input  logic              core_busy,
  input  logic              clk_running,
  input  logic              presc_run,
  output logic              core_clk_en,
  output logic              presc_halt
);

  ctl_t ctl;
  logic fall_evt, wake_evt, race_evt, deny_evt;
  logic frz_ack, stop_ack;

  pmm_rx_edge #(.STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_in    (can_rx),
    .fall_evt (fall_evt)
  );

  pmm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_supv  (acc_supv),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .fall_evt  (fall_evt),
    .frz_ack   (frz_ack),
    .stop_ack  (stop_ack),
    .ctl_q     (ctl),
    .rd_data   (rd_data),
    .acc_err   (acc_err),
    .wake_evt  (wake_evt),
    .race_evt  (race_evt),
    .deny_evt  (deny_evt)
  );

  pmm_clk_ctl u_clk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (ctl.stop),
    .frz_req     (ctl.frz),
    .aps_en      (ctl.aps),
    .core_busy   (core_busy),
    .clk_running (clk_running),
    .presc_run   (presc_run),
    .clk_en_q    (core_clk_en),
    .stop_ack_q  (stop_ack),
    .frz_ack_q   (frz_ack)
  );

  assign presc_halt = ctl.frz;

  // R5: a wake event restores the enable two edges later (stop clears, then enable)
  p_wake_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !ctl.aps) |=> ##1 core_clk_en);

  // R6: a refused self-wake write never removes a running clock
  p_race_keeps_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (race_evt && !ctl.stop && !ctl.aps) |=> ##1 core_clk_en);

  // R9: errors only come from refused protected accesses
  p_err_only_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> $past(deny_evt));

endmodule

// File: tb/can_pwr_mode_mgr_test.sv
module can_pwr_mode_mgr_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, acc_supv = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic       acc_err;
  logic       can_rx = 1'b1, core_busy = 1'b1;
  logic       clk_running = 1'b1, presc_run = 1'b1;
  logic       core_clk_en, presc_halt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_pwr_mode_mgr uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_supv(acc_supv), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .acc_err(acc_err), .can_rx(can_rx), .core_busy(core_busy),
    .clk_running(clk_running), .presc_run(presc_run),
    .core_clk_en(core_clk_en), .presc_halt(presc_halt)
  );

  // ---------------- behavioural reference model ----------------
  bit   m_stop, m_frz, m_sw, m_aps, m_supv, m_fack, m_sack, m_en, m_err;
  bit   m_rx[$];            // [0] newest synchronizer sample ... [2] previous sample
  logic [7:0] m_rd;
  logic [7:0] m_prot [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stop = 0; m_frz = 0; m_sw = 0; m_aps = 0; m_supv = 1;
      m_fack = 0; m_sack = 0; m_en = 1; m_err = 0; m_rd = 0;
      m_rx = '{1, 1, 1};
      foreach (m_prot[i]) m_prot[i] = 0;
    end else begin
      bit fall, prot, den, n_stop, n_sw, n_en, n_sack, n_fack;
      logic [7:0] n_rd;
      fall = m_rx[2] && !m_rx[1];
      prot = acc_valid && acc_addr >= 1 && acc_addr <= 4;
      den  = prot && m_supv && !acc_supv;
      n_en = (m_stop || (m_aps && !core_busy)) ? 0 : 1;
      n_sack = m_sack;
      if (m_stop && !m_en && !clk_running) n_sack = 1; else if (clk_running) n_sack = 0;
      n_fack = m_fack;
      if (m_frz && !presc_run) n_fack = 1; else if (!m_frz && presc_run) n_fack = 0;
      n_rd = 0;
      if (acc_valid && !acc_write) begin
        if (acc_addr == 0)
          n_rd = {1'b0, m_sack, m_fack, m_supv, m_aps, m_sw, m_frz, m_stop};
        else if (prot && !den) n_rd = m_prot[acc_addr - 1];
      end
      n_stop = m_stop; n_sw = m_sw;
      if (acc_valid && acc_write && acc_addr == 0) begin
        if (!(acc_wdata[2] && !m_sw && fall)) begin
          n_stop = acc_wdata[0]; n_sw = acc_wdata[2];
        end
        m_frz = acc_wdata[1]; m_aps = acc_wdata[3]; m_supv = acc_wdata[4];
      end
      if (m_stop && m_sw && fall) n_stop = 0;
      if (prot && acc_write && !den) m_prot[acc_addr - 1] = acc_wdata;
      m_stop = n_stop; m_sw = n_sw; m_en = n_en; m_sack = n_sack; m_fack = n_fack;
      m_rd = n_rd; m_err = den;
      void'(m_rx.pop_back());
      m_rx.push_front(can_rx);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every cycle, then update the gating cell and prescaler models
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R7 core_clk_en", core_clk_en, m_en);
      chk("R4 presc_halt", presc_halt, m_frz);
      chk("R10 rd_data", rd_data, m_rd);
      chk("R8 R9 acc_err", acc_err, m_err);
    end
    clk_running = core_clk_en;
    presc_run   = !presc_halt;
  end

  // ---------------- access tasks (called at a falling edge) ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit sv);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; acc_supv = sv;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit sv, input logic [7:0] exp,
                    input bit exp_err, input string tag);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_supv = sv;
    @(negedge clk);
    chk(tag, rd_data, exp);
    chk({tag, " err"}, acc_err, exp_err);
    acc_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 halt", presc_halt, 0);
    rd(0, 0, 8'h10, 0, "R1 ctl reset");

    // R8 supervisor gating of protected bank
    wr(1, 8'hA5, 1);
    rd(1, 0, 8'h00, 1, "R8 user read refused");
    wr(1, 8'h3C, 0);
    chk("R9 err pulse", acc_err, 1);
    rd(1, 1, 8'hA5, 0, "R8 write ignored");
    wr(0, 8'h00, 0);                     // R10: ctl reachable from user
    rd(1, 0, 8'hA5, 0, "R8 user allowed");
    rd(7, 0, 8'h00, 0, "R10 unmapped");

    // R4 freeze handshake
    wr(0, 8'h02, 1);
    idle(4);
    chk("R4 halt", presc_halt, 1);
    rd(0, 1, 8'h22, 0, "R4 freeze ack set");
    wr(0, 8'h00, 1);
    idle(4);
    rd(0, 1, 8'h00, 0, "R4 freeze ack clear");

    // R2 R3 stop handshake
    wr(0, 8'h01, 1);
    idle(4);
    chk("R2 stop gates", core_clk_en, 0);
    rd(0, 1, 8'h41, 0, "R3 stop ack set");
    wr(0, 8'h00, 1);
    idle(4);
    chk("R2 restart", core_clk_en, 1);
    rd(0, 1, 8'h00, 0, "R3 stop ack clear");

    // R5 self-wake on a bus fall
    wr(0, 8'h05, 1);
    idle(4);
    rd(0, 1, 8'h45, 0, "R5 stopped with self-wake");
    can_rx = 0;
    idle(6);
    chk("R5 clock back", core_clk_en, 1);
    rd(0, 1, 8'h04, 0, "R5 stop cleared");
    can_rx = 1;
    idle(4);
    rd(0, 1, 8'h04, 0, "R5 rise ignored");
    wr(0, 8'h00, 1);
    idle(2);

    // R6 race: self-wake write lands on the detection cycle
    can_rx = 0;
    idle(2);
    wr(0, 8'h05, 1);
    idle(3);
    chk("R6 clock kept", core_clk_en, 1);
    rd(0, 1, 8'h00, 0, "R6 write refused");
    can_rx = 1;
    idle(4);
    wr(0, 8'h04, 1);
    rd(0, 1, 8'h04, 0, "R6 quiet write accepted");
    wr(0, 8'h00, 1);

    // R7 auto power save
    wr(0, 8'h08, 1);
    idle(3);
    chk("R7 busy runs", core_clk_en, 1);
    core_busy = 0;
    idle(3);
    chk("R7 idle parks", core_clk_en, 0);
    rd(0, 1, 8'h08, 0, "R3 no ack under aps");
    core_busy = 1;
    idle(3);
    chk("R7 work restarts", core_clk_en, 1);
    wr(0, 8'h00, 1);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule